// File: doc/BRIEF.md
# Ready-Time Ordered Response Queue

This block keeps outgoing responses in order of the cycle at which each one may leave. Every entry carries a small tag and a ready time. The entries stay sorted by ready time. The entry at the head is offered to the consumer once a free-running cycle counter reaches its ready time. The same block serves as the response queue toward the processor side and as the snoop-reply queue toward the memory side.

An entry whose ready time is not below that of the current last entry goes straight to the tail. Any other entry is placed just ahead of the first entry that is strictly later, so two entries with the same ready time leave in the order they arrived.

The block rejects three kinds of enqueue:
- items that do not ask for a response, which are silently dropped;
- ready times already in the past, which raise an error pulse;
- any enqueue while the queue is full, which raises a stall.

An empty flag feeds the surrounding drain logic. A one-cycle arm pulse tells the sender that a new head has been started.

Top module: `resp_time_queue`

## Requirements
- R1: While reset is held and in the first cycle after it, `q_empty` is 1, `deq_valid` is 0 and `now_cycle` is 0.
- R2: `now_cycle` rises by exactly one on every clock edge after reset.
- R3: `enq_late_err` is high in any cycle where `enq_valid` is 1 and `enq_time` is below `now_cycle`, whatever `enq_needs_resp` is. Such an entry is never stored.
- R4: An enqueue with `enq_needs_resp` = 0 is dropped. It is not stored and raises neither `enq_stall` nor `send_arm`.
- R5: Entries leave in non-decreasing ready-time order. Entries with equal ready times leave in arrival order.
- R6: `deq_valid` is 1 exactly when the queue holds an entry and the head's ready time is at most `now_cycle`. `deq_tag` then shows the head's tag. The head is removed on a clock edge where both `deq_valid` and `deq_ready` are 1.
- R7: The queue holds at most DEPTH (default 8) entries. When DEPTH entries are held, an enqueue that is otherwise acceptable raises `enq_stall` and is not taken, even if a dequeue happens in the same cycle.
- R8: An accepted enqueue and a dequeue in the same cycle both take effect.
- R9: `q_empty` is 1 exactly when no entry is held.
- R10: `send_arm` is high for the one cycle in which an enqueue is accepted while the queue holds no entry other than a head being dequeued in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Enqueue request |
| enq_tag | input | TAG_W | Tag of the new entry |
| enq_time | input | 16 | Ready cycle of the new entry |
| enq_needs_resp | input | 1 | Entry needs a response; 0 means drop it |
| enq_late_err | output | 1 | Ready time lies in the past |
| enq_stall | output | 1 | Queue full, entry not taken |
| send_arm | output | 1 | New head started in an empty queue |
| deq_valid | output | 1 | Head is due |
| deq_tag | output | TAG_W | Tag of the head |
| deq_ready | input | 1 | Consumer takes the head |
| q_empty | output | 1 | No entry held |
| now_cycle | output | 16 | Current cycle count |

## Verification
Insertion and removal can fall in the same cycle. When that happens, the insert position must be found in the queue as it stands after the head has left. The arm pulse must likewise judge emptiness after the pop.

The bench provokes this in two ways. Directed steps enqueue while a lone due head is being taken. Random traffic keeps both ports busy most of the time. A reference model pops first and then inserts after the last entry whose time is not later. The following cycles' head tags, empty flag and arm pulse are compared against that model.

// File: rtl/rtq_pkg.sv
package rtq_pkg;
  localparam int TIME_W = 16;
  typedef logic [TIME_W-1:0] rtq_time_t;

  // strictly earlier
  function automatic logic rtq_before(rtq_time_t a, rtq_time_t b);
    return a < b;
  endfunction

  // ready time reached at cycle now
  function automatic logic rtq_due(rtq_time_t ready_at, rtq_time_t now);
    return !(now < ready_at);
  endfunction
endpackage

// File: rtl/rtq_cycle_timer.sv
module rtq_cycle_timer
  import rtq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  output rtq_time_t now
);
  always_ff @(posedge clk) begin
    if (!rst_n) now <= '0;
    else        now <= now + rtq_time_t'(1);
  end

  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> now == $past(now) + rtq_time_t'(1)); // R2
endmodule

// File: rtl/rtq_insert_locator.sv
module rtq_insert_locator
  import rtq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  rtq_time_t        pp_time [DEPTH],
  input  logic [CNT_W-1:0] pp_cnt,
  input  rtq_time_t        new_time,
  output logic [CNT_W-1:0] ins_idx
);
  rtq_time_t last_time;
  logic      append_tail;

  always_comb begin
    ins_idx   = '0;
    last_time = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (CNT_W'(i) < pp_cnt && !rtq_before(new_time, pp_time[i]))
        ins_idx = ins_idx + CNT_W'(1);
      if (CNT_W'(i + 1) == pp_cnt)
        last_time = pp_time[i];
    end
  end

  assign append_tail = (ins_idx == pp_cnt);

  AST_TAIL_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (push && append_tail && pp_cnt != '0) |-> !rtq_before(new_time, last_time)); // R5
endmodule

// File: rtl/rtq_slot_store.sv
module rtq_slot_store
  import rtq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TAG_W = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pop,
  input  logic             push,
  input  logic [CNT_W-1:0] ins_idx,
  input  logic [TAG_W-1:0] new_tag,
  input  rtq_time_t        new_time,
  output logic [TAG_W-1:0] head_tag,
  output rtq_time_t        head_time,
  output logic [CNT_W-1:0] cnt,
  output rtq_time_t        pp_time [DEPTH],
  output logic [CNT_W-1:0] pp_cnt
);
  logic [TAG_W-1:0] tag_q  [DEPTH];
  rtq_time_t        time_q [DEPTH];
  logic [TAG_W-1:0] pp_tag [DEPTH];
  logic [TAG_W-1:0] tag_d  [DEPTH];
  rtq_time_t        time_d [DEPTH];
  logic [CNT_W-1:0] cnt_q;

  assign pp_cnt    = cnt_q - CNT_W'(pop);
  assign cnt       = cnt_q;
  assign head_tag  = tag_q[0];
  assign head_time = time_q[0];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    // view after an optional pop
    if (i < DEPTH - 1) begin : g_shift
      assign pp_tag[i]  = pop ? tag_q[i+1]  : tag_q[i];
      assign pp_time[i] = pop ? time_q[i+1] : time_q[i];
    end else begin : g_last
      assign pp_tag[i]  = pop ? '0 : tag_q[i];
      assign pp_time[i] = pop ? '0 : time_q[i];
    end
    // insertion into the popped view
    if (i == 0) begin : g_first
      always_comb begin
        tag_d[i]  = pp_tag[i];
        time_d[i] = pp_time[i];
        if (push && ins_idx == '0) begin
          tag_d[i]  = new_tag;
          time_d[i] = new_time;
        end
      end
    end else begin : g_rest
      always_comb begin
        tag_d[i]  = pp_tag[i];
        time_d[i] = pp_time[i];
        if (push && ins_idx == CNT_W'(i)) begin
          tag_d[i]  = new_tag;
          time_d[i] = new_time;
        end else if (push && ins_idx < CNT_W'(i)) begin
          tag_d[i]  = pp_tag[i-1];
          time_d[i] = pp_time[i-1];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        tag_q[i]  <= '0;
        time_q[i] <= '0;
      end
    end else begin
      cnt_q <= pp_cnt + CNT_W'(push);
      for (int i = 0; i < DEPTH; i++) begin
        tag_q[i]  <= tag_d[i];
        time_q[i] <= time_d[i];
      end
    end
  end

  for (genvar i = 0; i < DEPTH - 1; i++) begin : g_chk
    AST_SORTED: assert property (@(posedge clk) disable iff (!rst_n)
      (CNT_W'(i + 1) < cnt_q) |-> !rtq_before(time_q[i+1], time_q[i])); // R5
  end

  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> cnt_q != '0); // R6
endmodule

// File: rtl/resp_time_queue.sv
module resp_time_queue
  import rtq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TAG_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enq_valid,
  input  logic [TAG_W-1:0]  enq_tag,
  input  logic [TIME_W-1:0] enq_time,
  input  logic              enq_needs_resp,
  output logic              enq_late_err,
  output logic              enq_stall,
  output logic              send_arm,
  output logic              deq_valid,
  output logic [TAG_W-1:0]  deq_tag,
  input  logic              deq_ready,
  output logic              q_empty,
  output logic [TIME_W-1:0] now_cycle
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  rtq_time_t        now;
  rtq_time_t        head_time;
  rtq_time_t        pp_time [DEPTH];
  logic [CNT_W-1:0] cnt_w, pp_cnt, ins_idx;
  logic [TAG_W-1:0] head_tag;
  // named events
  logic late_ev, want_ev, full_ev, push_ev, pop_ev;

  rtq_cycle_timer u_timer (.clk(clk), .rst_n(rst_n), .now(now));

  assign late_ev   = enq_valid && rtq_before(enq_time, now);
  assign want_ev   = enq_valid && enq_needs_resp && !late_ev;
  assign full_ev   = (cnt_w == CNT_W'(DEPTH));
  assign push_ev   = want_ev && !full_ev;
  assign deq_valid = (cnt_w != '0) && rtq_due(head_time, now);
  assign pop_ev    = deq_valid && deq_ready;

  rtq_insert_locator #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_loc (
    .clk(clk), .rst_n(rst_n), .push(push_ev), .pp_time(pp_time),
    .pp_cnt(pp_cnt), .new_time(enq_time), .ins_idx(ins_idx));

  rtq_slot_store #(.DEPTH(DEPTH), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_store (
    .clk(clk), .rst_n(rst_n), .pop(pop_ev), .push(push_ev),
    .ins_idx(ins_idx), .new_tag(enq_tag), .new_time(enq_time),
    .head_tag(head_tag), .head_time(head_time), .cnt(cnt_w),
    .pp_time(pp_time), .pp_cnt(pp_cnt));

  assign enq_late_err = late_ev;
  assign enq_stall    = want_ev && full_ev;
  assign send_arm     = push_ev && (pp_cnt == '0);
  assign deq_tag      = head_tag;
  assign q_empty      = (cnt_w == '0);
  assign now_cycle    = now;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_w <= CNT_W'(DEPTH)); // R7
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    enq_stall |=> cnt_w <= $past(cnt_w)); // R7
  AST_LATE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    enq_late_err |=> cnt_w <= $past(cnt_w)); // R3
  AST_DROP_NORESP: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_valid && !enq_needs_resp) |=> cnt_w <= $past(cnt_w)); // R4
  AST_BOTH_HONOURED: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ev && pop_ev) |=> cnt_w == $past(cnt_w)); // R8
  AST_ARM_NEW_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    send_arm |=> cnt_w == CNT_W'(1)); // R10
  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    q_empty |-> !deq_valid); // R9
endmodule

// File: tb/sim_resp_time_queue.sv
module sim_resp_time_queue;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic        clk = 0, rst_n = 0;
  logic        enq_valid = 0, enq_needs_resp = 0, deq_ready = 0;
  logic [7:0]  enq_tag = 0;
  logic [15:0] enq_time = 0;
  logic        enq_late_err, enq_stall, send_arm, deq_valid, q_empty;
  logic [7:0]  deq_tag;
  logic [15:0] now_cycle;

  int checks = 0, errors = 0;
  int m_now = 0, m_cnt = 0;
  int m_tag [DEPTH];
  int m_time[DEPTH];
  int next_tag = 1;
  bit both_prev = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  resp_time_queue #(.DEPTH(DEPTH), .TAG_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_tag(enq_tag),
    .enq_time(enq_time), .enq_needs_resp(enq_needs_resp),
    .enq_late_err(enq_late_err), .enq_stall(enq_stall), .send_arm(send_arm),
    .deq_valid(deq_valid), .deq_tag(deq_tag), .deq_ready(deq_ready),
    .q_empty(q_empty), .now_cycle(now_cycle));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, m_now);
    end
  endtask

  // index after the last model entry not later than t
  function automatic int model_slot(int t);
    int p = 0;
    for (int i = 0; i < m_cnt; i++) if (m_time[i] <= t) p = i + 1;
    return p;
  endfunction

  // one cycle: drive at negedge, judge, advance the model past the edge
  task automatic step(bit ev, int tg, int tm, bit nr, bit rdy);
    bit late, dv, pop, want, stall, push;
    int pos;
    enq_valid = ev; enq_tag = tg[7:0]; enq_time = tm[15:0];
    enq_needs_resp = nr; deq_ready = rdy;
    #1;
    late  = ev && (tm < m_now);
    dv    = (m_cnt > 0) && (m_time[0] <= m_now);
    pop   = dv && rdy;
    want  = ev && nr && !late;
    stall = want && (m_cnt == DEPTH);
    push  = want && !stall;
    check("R2 now_cycle", int'(now_cycle), m_now);
    check(both_prev ? "R8 q_empty after enq+deq" : "R9 q_empty", int'(q_empty), int'(m_cnt == 0));
    check("R6 deq_valid", int'(deq_valid), int'(dv));
    if (dv) check("R5 head tag order", int'(deq_tag), m_tag[0]);
    check("R3 late error", int'(enq_late_err), int'(late));
    check("R7 stall", int'(enq_stall), int'(stall));
    check("R10 send_arm", int'(send_arm), int'(push && (m_cnt - int'(pop)) == 0));
    if (ev && !nr) begin
      check("R4 dropped no stall", int'(enq_stall), 0);
      check("R4 dropped no arm", int'(send_arm), 0);
    end
    @(negedge clk);
    if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        m_tag[i] = m_tag[i+1]; m_time[i] = m_time[i+1];
      end
      m_cnt--;
    end
    if (push) begin
      pos = model_slot(tm);
      for (int i = DEPTH - 1; i > pos; i--) begin
        m_tag[i] = m_tag[i-1]; m_time[i] = m_time[i-1];
      end
      m_tag[pos] = tg; m_time[pos] = tm; m_cnt++;
    end
    both_prev = pop && push;
    m_now++;
  endtask

  task automatic idle(bit rdy);
    step(0, 0, 0, 0, rdy);
  endtask

  function automatic int fresh_tag();
    next_tag = (next_tag % 255) + 1;
    return next_tag;
  endfunction

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1 empty in reset", int'(q_empty), 1);
    check("R1 no valid in reset", int'(deq_valid), 0);
    check("R1 counter in reset", int'(now_cycle), 0);
    rst_n = 1;

    // R4: drop into an empty queue, then observe it stays empty
    step(1, fresh_tag(), 3, 0, 1);
    check("R4 still empty", int'(q_empty), 1);

    // R5: equal times keep arrival order, earlier time jumps ahead
    step(1, 11, m_now + 6, 1, 0);
    step(1, 12, m_now + 5, 1, 0);
    step(1, 13, m_now + 2, 1, 0);
    step(1, 14, m_now + 3, 1, 0);
    repeat (6) idle(0);
    repeat (5) idle(1);

    // R3: late enqueue
    step(1, 20, m_now - 1, 1, 1);
    step(1, 21, 0, 0, 1);
    check("R3 late not stored", int'(q_empty), 1);

    // R7: fill, then stall even with a same-cycle dequeue
    for (int k = 0; k < DEPTH; k++) step(1, 30 + k, m_now, 1, 0);
    step(1, 40, m_now + 1, 1, 0);
    step(1, 41, m_now + 1, 1, 1);
    repeat (DEPTH + 2) idle(1);

    // R8/R10: lone due head taken while a new entry arrives
    step(1, 50, m_now, 1, 0);
    step(1, 51, m_now + 3, 1, 1);
    repeat (5) idle(1);

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      bit ev, nr, rdy;
      int tm;
      ev  = ($urandom % 4) != 0;
      nr  = ($urandom % 8) != 0;
      rdy = ($urandom % 3) != 0;
      tm  = m_now + int'($urandom % 10);
      if (($urandom % 10) == 0 && m_now > 3) tm = m_now - 1 - int'($urandom % 3);
      step(ev, fresh_tag(), tm, nr, rdy);
    end
    repeat (20) idle(1);
    check("R9 drained", int'(q_empty), 1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule